// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is a timer that counts up from zero with one compare channel and drives a single PWM output. A prescaler divides the input clock, so that the counter advances once every (prescale + 1) clocks. The counter runs from 0 up to the period value and then returns to 0. The output waveform is formed by comparing the running count against a compare value. Two opposite polarity modes are available.

Software programs the block through a narrow write-only port with four word addresses:

- Address 0 is control: bit 0 starts the counter, bit 1 enables the output, bit 2 enables compare preload, and bits 6:4 hold the output mode.
- Address 1 is the prescaler.
- Address 2 is the period.
- Address 3 is the compare value.

Prescaler and period writes always go to holding registers. These are copied into the working registers when the counter wraps. With preload enabled, compare writes are held the same way, so a period in progress is never cut short or stretched. A control write with the start bit set clears the counter and the prescaler and loads every holding register at once.

The current count is brought out for observation. The PWM output and the count are both registered outputs.

Top module: `pwm_timer_chan`

## Requirements
- R1: While running, the counter advances by one once every (P+1) clocks, where P is the active prescaler value.
- R2: The counter counts 0, 1, …, A and then wraps to 0, so one PWM period is A+1 counter steps. A is the active period value.
- R3: With mode 3'b110, the output is high while the count is below the compare value and low otherwise. The output reflects the count of the preceding clock. A compare of 0 gives a constant low output; a compare above A gives a constant high output.
- R4: With mode 3'b111, the output is low while the count is below the compare value and high otherwise.
- R5: Any mode value other than 3'b110 and 3'b111 holds the output low while the counter keeps counting.
- R6: With preload enabled (control bit 2 = 1), a compare write takes effect only from the wrap that follows it.
- R7: With preload disabled, a compare write takes effect at the first counter step after the write.
- R8: Period and prescaler writes made while running take effect only from the next wrap.
- R9: With control bit 1 clear, the output is held low while the counter runs.
- R10: With control bit 0 clear, the count and prescaler hold their values and the output is low. This is also the state after reset, with a count of 0.
- R11: A control write with bit 0 set returns the count to 0 on that clock and loads the prescaler, period and compare holding values immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 control, 1 prescaler, 2 period, 3 compare |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Registered PWM waveform |
| count_out | output | 16 | Registered counter value |

## Verification
The bench sweeps both PWM modes over every compare value from 0 to one past the period, for several periods and prescalers. A design that mishandles the extremes would glitch where the output must be flat at compare 0 or above the period. It writes the compare value mid-period both with and without preload. A design with a wrong load point would change the waveform one period early or one step late. It reprograms the period and prescaler mid-run. A design lacking shadowing would wrap at the new period at once instead of after the current one. It also stops the counter mid-run, disables the output and selects unused modes. Here the errors are a drifting count or a still-toggling pin.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PSC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd3;

  localparam int CTL_RUN   = 0;
  localparam int CTL_OE    = 1;
  localparam int CTL_PRE   = 2;
  localparam int CTL_MODE  = 4;
  localparam int MODE_W    = 3;

  typedef enum logic [MODE_W-1:0] {
    WAVE_HIGH_FIRST = 3'b110,
    WAVE_LOW_FIRST  = 3'b111
  } wave_mode_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              preload;
    logic              oe;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  input  logic              wrap,
  output logic              restart,
  output ctrl_t             ctrl,
  output logic [PSC_W-1:0]  psc_act,
  output logic [CNT_W-1:0]  per_act,
  output logic [CNT_W-1:0]  cmp_act
);
  logic [PSC_W-1:0] psc_buf;
  logic [CNT_W-1:0] per_buf;
  logic [CNT_W-1:0] cmp_buf;
  logic             wr_ctrl;
  logic             load_cmp;

  assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
  assign restart  = wr_ctrl && wr_data[CTL_RUN];
  assign load_cmp = restart || (wrap && ctrl.preload) || (tick && !ctrl.preload);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      psc_buf <= '0;
      per_buf <= '0;
      cmp_buf <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          ctrl.run     <= wr_data[CTL_RUN];
          ctrl.oe      <= wr_data[CTL_OE];
          ctrl.preload <= wr_data[CTL_PRE];
          ctrl.mode    <= wr_data[CTL_MODE +: MODE_W];
        end
        ADDR_PSC: psc_buf <= wr_data[PSC_W-1:0];
        ADDR_PER: per_buf <= wr_data[CNT_W-1:0];
        default:  cmp_buf <= wr_data[CNT_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_act <= '0;
      per_act <= '0;
    end else if (restart || wrap) begin
      psc_act <= psc_buf;
      per_act <= per_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_act <= '0;
    end else if (load_cmp) begin
      cmp_act <= cmp_buf;
    end
  end

  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctrl.preload && !wrap && !restart) |=> $stable(cmp_act)); // R6

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wrap && !restart) |=> ($stable(per_act) && $stable(psc_act))); // R8
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc_act,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;
  logic             at_end;

  assign at_end = (div_q >= psc_act);
  assign tick   = run && !restart && at_end;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (run) begin
      if (at_end) div_q <= '0;
      else        div_q <= div_q + 1'b1;
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst)
    div_q <= psc_act); // R1

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(div_q)); // R10
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = tick && (cnt_q >= per_act);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (wrap) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_act); // R2

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wrap && !restart) |=> (cnt_q == '0)); // R2

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              oe,
  input  logic [MODE_W-1:0] mode,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp_act,
  output logic              pwm
);
  logic below;
  logic wave;

  assign below = (cnt < cmp_act);

  always_comb begin
    case (mode)
      WAVE_HIGH_FIRST: wave = below;
      WAVE_LOW_FIRST:  wave = !below;
      default:         wave = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= run && oe && wave;
  end

  AST_OE_LOW: assert property (@(posedge clk) disable iff (rst)
    !oe |=> !pwm); // R9

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pwm); // R10

  AST_MODE_LOW: assert property (@(posedge clk) disable iff (rst)
    ((mode != WAVE_HIGH_FIRST) && (mode != WAVE_LOW_FIRST)) |=> !pwm); // R5
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out,
  output logic [CNT_W-1:0]  count_out
);
  ctrl_t            ctrl;
  logic             restart;
  logic             tick;
  logic             wrap;
  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] per_act;
  logic [CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0] cnt;

  pwm_cfg_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .wrap(wrap), .restart(restart), .ctrl(ctrl),
    .psc_act(psc_act), .per_act(per_act), .cmp_act(cmp_act)
  );

  pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(ctrl.run), .restart(restart),
    .psc_act(psc_act), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart),
    .per_act(per_act), .cnt(cnt), .wrap(wrap)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .run(ctrl.run), .oe(ctrl.oe), .mode(ctrl.mode),
    .cnt(cnt), .cmp_act(cmp_act), .pwm(pwm_out)
  );

  assign count_out = cnt;

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (count_out == '0)); // R11
endmodule

// File: tb/sim_pwm_timer_chan.sv
module sim_pwm_timer_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out;
  logic [15:0] count_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_timer_chan u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .count_out(count_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = a[1:0];
    wr_data = d[15:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int ctl(input int run, input int oe, input int pre, input int mode);
    return run | (oe << 1) | (pre << 2) | (mode << 4);
  endfunction

  function automatic int expf(input int mode, input int oe, input int c, input int cv);
    if (oe == 0) return 0;
    if (mode == 6) return (c < cv) ? 1 : 0;
    if (mode == 7) return (c >= cv) ? 1 : 0;
    return 0;
  endfunction

  task automatic sweep_run(input int p, input int a, input int cv, input int mode);
    wr(1, p);
    wr(2, a);
    wr(3, cv);
    wr(0, ctl(1, 1, 0, mode));
    chk("R11", count_out, 0);
    for (int k = 1; k <= 2 * (a + 1) * (p + 1) + 1; k++) begin
      step();
      chk((p == 0) ? "R2" : "R1", count_out, (k / (p + 1)) % (a + 1));
      chk((mode == 6) ? "R3" : "R4", pwm_out,
          expf(mode, 1, ((k - 1) / (p + 1)) % (a + 1), cv));
    end
  endtask

  task automatic cmp_update(input int pre);
    int cu;
    wr(1, 0);
    wr(2, 7);
    wr(3, 2);
    wr(0, ctl(1, 1, pre, 6));
    for (int k = 1; k <= 4; k++) step();
    wr(3, 7);
    chk(pre ? "R6" : "R7", pwm_out, expf(6, 1, 4, 2));
    for (int k = 6; k <= 24; k++) begin
      step();
      if (pre != 0) cu = ((k - 1) >= 8) ? 7 : 2;
      else          cu = ((k - 1) >= 6) ? 7 : 2;
      chk(pre ? "R6" : "R7", pwm_out, expf(6, 1, (k - 1) % 8, cu));
    end
  endtask

  initial begin
    int held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    step();
    chk("R10", count_out, 0);
    chk("R10", pwm_out, 0);

    // R1 R2 R3 R4 R11: sweep of both modes, compare values, periods, prescalers
    for (int mi = 6; mi <= 7; mi++)
      for (int p = 0; p <= 2; p += 2)
        for (int a = 3; a <= 5; a += 2)
          for (int cv = 0; cv <= a + 1; cv++)
            sweep_run(p, a, cv, mi);

    // R10: stop mid-run
    wr(1, 0);
    wr(2, 9);
    wr(3, 10);
    wr(0, ctl(1, 1, 0, 6));
    for (int k = 1; k <= 3; k++) step();
    wr(0, ctl(0, 1, 0, 6));
    held = count_out;
    chk("R10", held, 4);
    for (int k = 0; k < 10; k++) begin
      step();
      chk("R10", count_out, 4);
      chk("R10", pwm_out, 0);
    end

    // R5: unused mode value
    wr(0, ctl(1, 1, 0, 5));
    for (int k = 1; k <= 20; k++) begin
      step();
      chk("R5", pwm_out, 0);
      chk("R5", count_out, k % 10);
    end

    // R9: output disabled
    wr(0, ctl(1, 0, 0, 6));
    for (int k = 1; k <= 20; k++) begin
      step();
      chk("R9", pwm_out, 0);
      chk("R9", count_out, k % 10);
    end

    // R6 / R7: compare update with and without preload
    cmp_update(1);
    cmp_update(0);

    // R8: period written mid-run
    wr(1, 0);
    wr(2, 3);
    wr(0, ctl(1, 1, 0, 6));
    step();
    wr(2, 6);
    for (int k = 2; k <= 14; k++) begin
      if (k > 2) step();
      chk("R8", count_out, (k < 4) ? k : (k - 4) % 7);
    end

    // R8: prescaler written mid-run
    wr(2, 3);
    wr(0, ctl(1, 1, 0, 6));
    step();
    wr(1, 2);
    for (int k = 2; k <= 20; k++) begin
      if (k > 2) step();
      chk("R8", count_out, (k < 4) ? k : ((k - 4) / 3) % 4);
    end

    // R11: restart loads held values at once
    wr(1, 0);
    wr(2, 5);
    wr(0, ctl(1, 1, 0, 6));
    chk("R11", count_out, 0);
    for (int k = 1; k <= 13; k++) begin
      step();
      chk("R11", count_out, k % 6);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule